// File: doc/BRIEF.md
# I2C Bus Master with Stall-Per-Byte Register Control

This block is a register-controlled master for a two-wire I2C bus. Software drives it one byte at a time. It puts a byte in the data register, then writes a mode and start code to the status register. The controller then issues a START condition and shifts the byte out MSB first. It samples the acknowledge bit on the ninth clock. After that it parks the bus with SCL low and raises a pending flag, and it waits until software writes that flag back to 1.

Between bytes software can do one of four things:
- load another byte to send,
- choose ACK or NAK for the next received byte,
- request a repeated START,
- request a STOP.

Byte-done, START and STOP events are collected in a separate event register with per-event enables. The enabled events are combined onto one interrupt line. A ready register tells software when the previous register write has been absorbed. Both bus lines are open-drain: an `_oe_o` output that is high pulls the line low.

Top module: `i2c_master_ctrl`

## Requirements
- R1: Register offsets are control 0, status 1, data 2, own address 3, events 4 and ready 5. After reset, control, status, events and ready read 0, own address reads 0x40, and neither bus line is pulled low.
- R2: Any register write makes the ready register read 1 for exactly WR_LAT cycles (default 2). After that it reads 0. The own-address register reads back the 7-bit value written to it.
- R3: Writing 0xF0 to status means: bits 7:6 = 11 selects transmit, bit 5 requests start, bit 4 enables the outputs. This produces a START (SDA falls while SCL is high) followed by the data-register byte sent MSB first. Status bit 5 reads 1 while the transfer is active.
- R4: After the ninth clock of a byte, control bit 4 (pending) reads 1 and SCL stays low. Status bit 0 holds the sampled acknowledge: 0 means ACK, 1 means NAK.
- R5: While pending, writing the data register and then writing control with bit 4 = 1 transmits that byte as the next one.
- R6: Clearing status bit 5 while busy, then writing control bit 4 = 1, produces a STOP (SDA rises while SCL is high). Both lines end released and status bit 5 reads 0.
- R7: Writing 0xB0 to status (bits 7:6 = 10, receive) transmits the address byte and then receives every later byte. The data register holds the received byte once pending is set.
- R8: Control bit 7 decides the master's response on the ninth clock of a received byte: 1 drives ACK (SDA low), 0 leaves NAK (SDA released).
- R9: Writing 0xB0 or 0xF0 to status while pending issues a repeated START with no STOP in between.
- R10: Event register bit 8 is set on byte done, bit 12 on START and bit 13 on STOP. Writing 1 to a bit clears only that bit.
- R11: irq_o is high exactly when some event bit is set and control holds a 1 at the same bit position (13:8).
- R12: The SCL period is P*(D+1) clock cycles. P is 32 when control bit 6 is 1 and 16 when it is 0. D is control bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational on reg_addr_i) |
| scl_i | input | 1 | SCL line level (not used by the block) |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low |
| irq_o | output | 1 | Enabled event pending |

## Verification
The transfer engine is tried with four bus patterns:
- a write where both the address and the data are acknowledged, which separates correct shift order and pending behaviour from a wrong bit order;
- an address that no device acknowledges, which shows the ACK sample reaching status bit 0;
- a write followed by a repeated START into a two-byte read, once with ACK and once with NAK, which separates the receive path and the ACK/NAK choice from transmit;
- two clock settings, whose measured SCL periods distinguish the prescaler from the divider.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 16;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_DATA = 3'd2,
    A_OWN  = 3'd3,
    A_EVT  = 3'd4,
    A_RDY  = 3'd5
  } reg_addr_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT, S_HOLD, S_STOP
  } eng_state_e;
endpackage

// File: rtl/i2cm_clkgen.sv
module i2cm_clkgen #(
  parameter int DIV_W    = 4,
  parameter int PRESC_LO = 16,
  parameter int PRESC_HI = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             presc_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + $clog2(PRESC_HI / 4) + 1;
  localparam logic [CNT_W-1:0] Q_LO = CNT_W'(PRESC_LO / 4);
  localparam logic [CNT_W-1:0] Q_HI = CNT_W'(PRESC_HI / 4);

  logic [CNT_W-1:0] qlen, cnt_q;

  // quarter SCL period in clock cycles
  assign qlen = (CNT_W'(div_i) + CNT_W'(1)) * (presc_sel_i ? Q_HI : Q_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == qlen - CNT_W'(1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R12
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       go_start_i,
  input  logic       rx_i,
  input  logic       go_cont_i,
  input  logic       stop_i,
  input  logic       ack_en_i,
  input  logic [7:0] tx_byte_i,
  input  logic       sda_i,
  output logic       scl_lo_o,
  output logic       sda_lo_o,
  output logic       busy_o,
  output logic       pend_o,
  output logic       ack_o,
  output logic [7:0] rx_byte_o,
  output logic       byte_ev_o,
  output logic       start_ev_o,
  output logic       stop_ev_o
);
  eng_state_e state_q;
  logic [1:0] q_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       rx_q, first_q;
  logic       tx_now;

  assign tx_now    = first_q || !rx_q;
  assign busy_o    = (state_q != S_IDLE);
  assign pend_o    = (state_q == S_HOLD);
  assign rx_byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      q_q        <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      rx_q       <= 1'b0;
      first_q    <= 1'b0;
      ack_o      <= 1'b0;
      scl_lo_o   <= 1'b0;
      sda_lo_o   <= 1'b0;
      byte_ev_o  <= 1'b0;
      start_ev_o <= 1'b0;
      stop_ev_o  <= 1'b0;
    end else begin
      byte_ev_o  <= 1'b0;
      start_ev_o <= 1'b0;
      stop_ev_o  <= 1'b0;
      if ((state_q == S_IDLE || state_q == S_HOLD) && go_start_i) begin
        state_q <= S_START;
        q_q     <= '0;
        sh_q    <= tx_byte_i;
        rx_q    <= rx_i;
        first_q <= 1'b1;
      end else if (state_q == S_HOLD && go_cont_i) begin
        q_q     <= '0;
        bit_q   <= '0;
        sh_q    <= tx_byte_i;
        state_q <= stop_i ? S_STOP : S_BIT;
      end else if (tick_i) begin
        q_q <= q_q + 2'd1;
        unique case (state_q)
          S_START: unique case (q_q)
            2'd0: sda_lo_o <= 1'b0;
            2'd1: scl_lo_o <= 1'b0;
            2'd2: begin sda_lo_o <= 1'b1; start_ev_o <= 1'b1; end
            default: begin scl_lo_o <= 1'b1; state_q <= S_BIT; bit_q <= '0; end
          endcase
          S_BIT: unique case (q_q)
            2'd0: if (bit_q == 4'd8) sda_lo_o <= !tx_now && ack_en_i;
                  else               sda_lo_o <= tx_now && !sh_q[7];
            2'd1: scl_lo_o <= 1'b0;
            2'd2: if (bit_q == 4'd8) ack_o <= sda_i;
                  else               sh_q  <= {sh_q[6:0], sda_i};
            default: begin
              scl_lo_o <= 1'b1;
              if (bit_q == 4'd8) begin
                state_q   <= S_HOLD;
                byte_ev_o <= 1'b1;
                first_q   <= 1'b0;
                sda_lo_o  <= 1'b0;
              end else begin
                bit_q <= bit_q + 4'd1;
              end
            end
          endcase
          S_STOP: unique case (q_q)
            2'd0: sda_lo_o <= 1'b1;
            2'd1: scl_lo_o <= 1'b0;
            2'd2: begin sda_lo_o <= 1'b0; stop_ev_o <= 1'b1; end
            default: state_q <= S_IDLE;
          endcase
          default: ;
        endcase
      end
    end
  end

  // R4
  pend_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> scl_lo_o);
  // R3
  start_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev_o |-> (sda_lo_o && !scl_lo_o));
  // R6
  stop_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ev_o |-> (!sda_lo_o && !scl_lo_o));
endmodule

// File: rtl/i2c_master_ctrl.sv
module i2c_master_ctrl
  import i2cm_pkg::*;
#(
  parameter int DIV_W    = 4,
  parameter int PRESC_LO = 16,
  parameter int PRESC_HI = 32,
  parameter int WR_LAT   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              scl_i,
  output logic              scl_oe_o,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              irq_o
);
  localparam int RDY_W = $clog2(WR_LAT + 1);

  logic             ack_en_q, presc_q, oe_q, stop_q;
  logic [DIV_W-1:0] div_q;
  logic [5:0]       ie_q;
  logic [1:0]       mode_q;
  logic [7:0]       data_q;
  logic [6:0]       own_q;
  logic [2:0]       evt_q;   // {stop, start, byte}
  logic [RDY_W-1:0] rdy_q;
  logic [5:0]       evt_vec;

  logic wr_ctrl, wr_stat, wr_data, wr_own, wr_evt;
  logic go_start, go_cont, tick;
  logic eng_scl_lo, eng_sda_lo, eng_busy, eng_pend, eng_ack;
  logic [7:0] eng_rx;
  logic byte_ev, start_ev, stop_ev;
  logic scl_unused;

  assign scl_unused = scl_i;
  assign wr_ctrl = reg_we_i && reg_addr_i == A_CTRL;
  assign wr_stat = reg_we_i && reg_addr_i == A_STAT;
  assign wr_data = reg_we_i && reg_addr_i == A_DATA;
  assign wr_own  = reg_we_i && reg_addr_i == A_OWN;
  assign wr_evt  = reg_we_i && reg_addr_i == A_EVT;

  assign go_start = wr_stat && reg_wdata_i[5] && reg_wdata_i[4] && (!eng_busy || eng_pend);
  assign go_cont  = wr_ctrl && reg_wdata_i[4] && eng_pend;

  i2cm_clkgen #(.DIV_W(DIV_W), .PRESC_LO(PRESC_LO), .PRESC_HI(PRESC_HI)) i_clkgen (
    .clk_i, .rst_ni,
    .en_i       (eng_busy && !eng_pend),
    .presc_sel_i(presc_q),
    .div_i      (div_q),
    .tick_o     (tick)
  );

  i2cm_engine i_engine (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .go_start_i(go_start),
    .rx_i      (!reg_wdata_i[6]),
    .go_cont_i (go_cont),
    .stop_i    (stop_q),
    .ack_en_i  (ack_en_q),
    .tx_byte_i (data_q),
    .sda_i     (sda_i),
    .scl_lo_o  (eng_scl_lo),
    .sda_lo_o  (eng_sda_lo),
    .busy_o    (eng_busy),
    .pend_o    (eng_pend),
    .ack_o     (eng_ack),
    .rx_byte_o (eng_rx),
    .byte_ev_o (byte_ev),
    .start_ev_o(start_ev),
    .stop_ev_o (stop_ev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_en_q <= 1'b0;
      presc_q  <= 1'b0;
      div_q    <= '0;
      ie_q     <= '0;
      mode_q   <= '0;
      oe_q     <= 1'b0;
      stop_q   <= 1'b0;
      data_q   <= '0;
      own_q    <= 7'h40;
      evt_q    <= '0;
      rdy_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        ack_en_q <= reg_wdata_i[7];
        presc_q  <= reg_wdata_i[6];
        div_q    <= reg_wdata_i[DIV_W-1:0];
        ie_q     <= reg_wdata_i[13:8];
      end
      if (wr_stat) begin
        mode_q <= reg_wdata_i[7:6];
        oe_q   <= reg_wdata_i[4];
        stop_q <= eng_busy && !reg_wdata_i[5];
      end else if (!eng_busy) begin
        stop_q <= 1'b0;
      end
      if (byte_ev)      data_q <= eng_rx;
      else if (wr_data) data_q <= reg_wdata_i[7:0];
      if (wr_own) own_q <= reg_wdata_i[6:0];
      evt_q <= (evt_q & ~({3{wr_evt}} & {reg_wdata_i[13], reg_wdata_i[12], reg_wdata_i[8]}))
             | {stop_ev, start_ev, byte_ev};
      if (reg_we_i)           rdy_q <= RDY_W'(WR_LAT);
      else if (rdy_q != '0)   rdy_q <= rdy_q - RDY_W'(1);
    end
  end

  assign scl_oe_o = oe_q && eng_scl_lo;
  assign sda_oe_o = oe_q && eng_sda_lo;
  assign evt_vec  = {evt_q[2], evt_q[1], 3'b000, evt_q[0]};
  assign irq_o    = |(evt_vec & ie_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: reg_rdata_o = {2'b00, ie_q, ack_en_q, presc_q, 1'b0, eng_pend, 4'(div_q)};
      A_STAT: reg_rdata_o = {8'h00, mode_q, eng_busy, oe_q, 3'b000, eng_ack};
      A_DATA: reg_rdata_o = {8'h00, data_q};
      A_OWN:  reg_rdata_o = {9'h000, own_q};
      A_EVT:  reg_rdata_o = {2'b00, evt_vec, 8'h00};
      A_RDY:  reg_rdata_o = {15'h0000, rdy_q != '0};
      default: reg_rdata_o = '0;
    endcase
  end

  // R2
  rdy_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (rdy_q != '0));
  // R10
  start_evt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[1]) |-> $past(start_ev));
  // R10
  stop_evt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[2]) |-> $past(stop_ev));
endmodule

// File: tb/test_i2c_master_ctrl.sv
module test_i2c_master_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        scl_oe, sda_oe, irq;
  logic        scl_bus, sda_bus;
  logic        slv_lo = 1'b0;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || slv_lo);

  always #(CLK_PERIOD/2) clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_master_ctrl i_i2c_master_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .scl_i(scl_bus), .scl_oe_o(scl_oe),
    .sda_i(sda_bus), .sda_oe_o(sda_oe), .irq_o(irq)
  );

  // simple slave on the bus
  logic       s_active = 1'b0, s_rd = 1'b0, ack_addr = 1'b1, m_ack = 1'b0;
  int         bitc = 0, byte_n = 0, starts = 0, stops = 0;
  logic [7:0] sh = '0, last_addr = '0, last_wr = '0;
  logic [7:0] rd_bytes [2];

  always @(negedge sda_bus) if (scl_bus) begin
    s_active = 1'b1; s_rd = 1'b0; bitc = 0; byte_n = 0; starts++; slv_lo = 1'b0;
  end
  always @(posedge sda_bus) if (scl_bus && s_active) begin
    s_active = 1'b0; stops++; slv_lo = 1'b0;
  end
  always @(posedge scl_bus) if (s_active) begin
    if (bitc < 8) begin sh = {sh[6:0], sda_bus}; bitc++; end
    else begin
      if (s_rd && byte_n > 0) m_ack = sda_bus;
      bitc = 9;
    end
  end
  always @(negedge scl_bus) if (s_active) begin
    if (bitc == 8) begin
      if (byte_n == 0) begin s_rd = sh[0]; last_addr = sh; slv_lo = ack_addr; end
      else if (!s_rd) begin last_wr = sh; slv_lo = 1'b1; end
      else slv_lo = 1'b0;
    end else if (bitc == 9) begin
      bitc = 0; byte_n++;
      if (s_rd && byte_n > 1 && m_ack) s_rd = 1'b0;
      slv_lo = (s_rd && byte_n <= 2) ? !rd_bytes[byte_n-1][7] : 1'b0;
    end else if (s_rd && byte_n > 0 && bitc > 0) begin
      slv_lo = !rd_bytes[byte_n-1][7-bitc];
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic wait_rdy();
    logic [15:0] v;
    do rd(3'd5, v); while (v != 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
    wait_rdy();
  endtask

  task automatic wait_pend();
    logic [15:0] v;
    do rd(3'd0, v); while (!v[4]);
    rd(3'd0, v);
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    do rd(3'd1, v); while (v[5]);
    rd(3'd1, v);
  endtask

  task automatic do_stop(input logic [15:0] ctrl);
    wr(3'd1, 16'h00D0);
    wr(3'd0, ctrl | 16'h0010);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 stat", v, 0);
    rd(3'd3, v); chk("R1 own", v, 16'h40);
    rd(3'd4, v); chk("R1 evt", v, 0);
    rd(3'd5, v); chk("R1 ready", v, 0);
    chk("R1 lines", {scl_bus, sda_bus}, 2'b11);
  endtask

  task automatic t_ready();
    logic [15:0] v;
    @(negedge clk); we = 1'b1; addr = 3'd3; wdata = 16'h0033;
    @(negedge clk); we = 1'b0; addr = 3'd5; #1;
    chk("R2 ready after write", rdata, 1);
    @(negedge clk); #1; chk("R2 ready second cycle", rdata, 1);
    @(negedge clk); #1; chk("R2 ready released", rdata, 0);
    rd(3'd3, v); chk("R2 own readback", v, 16'h33);
  endtask

  task automatic t_write();
    logic [15:0] v;
    int s0;
    s0 = starts;
    wr(3'd0, 16'h3180);
    wr(3'd2, 16'h00A4);
    wr(3'd1, 16'h00F0);
    rd(3'd1, v); chk("R3 busy bit", v[5], 1);
    wait_pend();
    chk("R3 start seen", starts - s0, 1);
    chk("R3 address byte", last_addr, 8'hA4);
    chk("R4 scl held low", scl_bus, 0);
    rd(3'd1, v); chk("R4 ack sampled", v[0], 0);
    rd(3'd4, v); chk("R10 byte+start evt", v, 16'h1100);
    chk("R11 irq set", irq, 1);
    wr(3'd4, 16'h0100);
    rd(3'd4, v); chk("R10 w1c selective", v, 16'h1000);
    wr(3'd2, 16'h005A);
    wr(3'd0, 16'h3190);
    wait_pend();
    chk("R5 data byte", last_wr, 8'h5A);
    s0 = stops;
    do_stop(16'h3180);
    chk("R6 stop seen", stops - s0, 1);
    chk("R6 lines released", {scl_bus, sda_bus}, 2'b11);
    rd(3'd1, v); chk("R6 busy clear", v[5], 0);
    rd(3'd4, v); chk("R10 stop evt", v & 16'h2000, 16'h2000);
    wr(3'd4, 16'h3100);
    rd(3'd4, v); chk("R10 all cleared", v, 0);
    chk("R11 irq clear", irq, 0);
    wr(3'd0, 16'h0080);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_irq_masked();
    logic [15:0] v;
    wr(3'd0, 16'h2080);
    wr(3'd2, 16'h00A4);
    wr(3'd1, 16'h00F0);
    wait_pend();
    rd(3'd4, v); chk("R10 evt with irq masked", v, 16'h1100);
    chk("R11 irq masked", irq, 0);
    do_stop(16'h2080);
    chk("R11 irq from stop", irq, 1);
    wr(3'd4, 16'h3100);
  endtask

  task automatic t_nak();
    logic [15:0] v;
    ack_addr = 1'b0;
    wr(3'd2, 16'h00A4);
    wr(3'd1, 16'h00F0);
    wait_pend();
    rd(3'd1, v); chk("R4 nak sampled", v[0], 1);
    do_stop(16'h0080);
    ack_addr = 1'b1;
    wr(3'd4, 16'h3100);
  endtask

  task automatic t_read_rs();
    logic [15:0] v;
    int s0, p0;
    rd_bytes[0] = 8'hC3; rd_bytes[1] = 8'h3C;
    wr(3'd0, 16'h0080);
    wr(3'd2, 16'h00A4);
    wr(3'd1, 16'h00F0);
    wait_pend();
    wr(3'd2, 16'h0007);
    wr(3'd0, 16'h0090);
    wait_pend();
    chk("R5 pointer byte", last_wr, 8'h07);
    s0 = starts; p0 = stops;
    wr(3'd2, 16'h00A5);
    wr(3'd1, 16'h00B0);
    wait_pend();
    chk("R9 repeated start", starts - s0, 1);
    chk("R9 no stop between", stops - p0, 0);
    chk("R9 read address", last_addr, 8'hA5);
    wr(3'd0, 16'h0090);
    wait_pend();
    rd(3'd2, v); chk("R7 first rx byte", v, 16'h00C3);
    chk("R8 master ack", m_ack, 0);
    wr(3'd0, 16'h0010);
    wait_pend();
    rd(3'd2, v); chk("R7 second rx byte", v, 16'h003C);
    chk("R8 master nak", m_ack, 1);
    p0 = stops;
    do_stop(16'h0000);
    chk("R6 stop after read", stops - p0, 1);
    wr(3'd4, 16'h3100);
  endtask

  task automatic t_clk(input logic [15:0] ctrl, input int period);
    int t1, t2;
    wr(3'd0, ctrl);
    wr(3'd2, 16'h00A4);
    wr(3'd1, 16'h00F0);
    @(posedge scl_bus); @(posedge scl_bus); t1 = cyc;
    @(posedge scl_bus); t2 = cyc;
    chk("R12 scl period", t2 - t1, period);
    wait_pend();
    do_stop(ctrl);
    wr(3'd4, 16'h3100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ready();
    t_write();
    t_irq_masked();
    t_nak();
    t_read_rs();
    t_clk(16'h0080, 16);
    t_clk(16'h00C1, 64);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule